// File: doc/BRIEF.md
# 16-bit Pointer Arithmetic Unit with Flags

This unit does the 16-bit address arithmetic of a small 8-bit processor core. Each cycle it takes an operation code, the current HL pair, a general register pair, the stack pointer, an 8-bit immediate and the current flag nibble. It returns a 16-bit result, a code that names the register which should take the result, and the updated flags. The register file, memory and instruction decode stay outside. The owning pipeline writes the result back as the destination code directs.

There are four operations. The first adds a register pair to HL and takes its flags from the carries out of bits 11 and 15. The second adds a signed 8-bit offset to the stack pointer. The third forms the same stack-pointer-plus-offset sum but sends it to HL. These two take their half-carry and carry from the unsigned addition of the low stack-pointer byte and the raw immediate byte, and they clear Zero and Subtract. The fourth decrements a pair by one and leaves the flags alone. All three adds and the decrement share one adder. The outputs are registered, so the latency is one cycle.

Top module: `addr_arith_unit`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, result is 0x0000, destination is 0 (none) and flags are 0x0.
- R2: Outputs are registered. Inputs presented before a rising clock edge appear at the outputs after that edge and hold until the next edge.
- R3: With opSel=1 (pair to HL), result = (hlIn + pairIn) mod 65536 and destination = 1 (HL). Flags are packed bit3 Zero, bit2 Subtract, bit1 Half-carry, bit0 Carry. Subtract = 0, Half-carry = carry out of bit 11, Carry = carry out of bit 15, and Zero is copied from flagsIn bit3.
- R4: The 8-bit immediate is a two's-complement offset. Its value is (imm XOR 0x80) - 0x80, for example 0xFF = -1 and 0x80 = -128.
- R5: With opSel=2 (offset to SP), result = (spIn + signed imm) mod 65536, destination = 2 (SP), and Zero and Subtract are 0.
- R6: For opSel 2 and 3, Half-carry = carry out of bit 3 and Carry = carry out of bit 7 of the unsigned sum spIn[7:0] + imm, whatever the sign of the offset.
- R7: With opSel=3 (SP plus offset to HL), result and flags are as in R5 and R6 and destination = 1 (HL).
- R8: With opSel=4 (decrement), result = (pairIn - 1) mod 65536, destination = 3 (pair), and flags equal flagsIn exactly.
- R9: opSel values 0, 5, 6 and 7 are idle. Result is 0x0000, destination is 0 and flags equal flagsIn.
- R10: Sums wrap. For example, 0xFFFF + 0x0001 with opSel=1 gives 0x0000 with Half-carry = 1 and Carry = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 3 | Operation code (0 idle, 1 pair to HL, 2 offset to SP, 3 SP+offset to HL, 4 decrement) |
| hlIn | input | 16 | Current HL pair |
| pairIn | input | 16 | Register pair operand |
| spIn | input | 16 | Current stack pointer |
| imm | input | 8 | Signed 8-bit offset |
| flagsIn | input | 4 | Current flags {Z,N,H,C} |
| result | output | 16 | Registered 16-bit result |
| dest | output | 2 | Registered destination (0 none, 1 HL, 2 SP, 3 pair) |
| flagsOut | output | 4 | Registered updated flags {Z,N,H,C} |

## Verification
The only state in the block is the output register. A wrong decode or a wrong operand selection therefore shows up at the ports on the very next sample, as a bad result, a bad destination code or a bad flag nibble. The bench compares every output field after every operation. The main risks are the carry taps: choosing wide flags where byte flags belong, or the reverse, goes wrong only for particular operand values. For that reason the directed cases put carries at bits 3, 7, 11 and 15 one at a time and use negative offsets. The checker also relates each operation code to the destination and flag rules one cycle later, so a decode error is reported on the cycle it happens.

// File: rtl/addr_arith_pkg.sv
package addr_arith_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_ADD_HL = 3'd1,
    OP_ADD_SP = 3'd2,
    OP_SP_HL  = 3'd3,
    OP_DEC    = 3'd4
  } opCodeT;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_HL   = 2'd1,
    DST_SP   = 2'd2,
    DST_PAIR = 2'd3
  } destT;

  typedef enum logic [1:0] {
    A_HL   = 2'd0,
    A_SP   = 2'd1,
    A_PAIR = 2'd2
  } aSelT;

  typedef enum logic [1:0] {
    B_PAIR   = 2'd0,
    B_OFFSET = 2'd1,
    B_MINUS1 = 2'd2
  } bSelT;

  typedef enum logic [1:0] {
    F_KEEP = 2'd0,
    F_WIDE = 2'd1,
    F_BYTE = 2'd2
  } flagModeT;

  // Strobes handed from decode to the datapath
  typedef struct packed {
    aSelT     aSel;
    bSelT     bSel;
    flagModeT flagMode;
    logic     zeroResult;
    destT     dest;
  } strobeT;

  // Flag nibble bit positions
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

endpackage

// File: rtl/addr_arith_ctrl.sv
module addr_arith_ctrl
  import addr_arith_pkg::*;
(
  input  logic [2:0] opSel,
  output strobeT     strobes
);

  always_comb begin
    strobes = '{aSel: A_HL, bSel: B_PAIR, flagMode: F_KEEP,
                zeroResult: 1'b1, dest: DST_NONE};
    case (opSel)
      OP_ADD_HL: strobes = '{aSel: A_HL, bSel: B_PAIR, flagMode: F_WIDE,
                             zeroResult: 1'b0, dest: DST_HL};
      OP_ADD_SP: strobes = '{aSel: A_SP, bSel: B_OFFSET, flagMode: F_BYTE,
                             zeroResult: 1'b0, dest: DST_SP};
      OP_SP_HL:  strobes = '{aSel: A_SP, bSel: B_OFFSET, flagMode: F_BYTE,
                             zeroResult: 1'b0, dest: DST_HL};
      OP_DEC:    strobes = '{aSel: A_PAIR, bSel: B_MINUS1, flagMode: F_KEEP,
                             zeroResult: 1'b0, dest: DST_PAIR};
      default: ;
    endcase
  end

endmodule

// File: rtl/addr_arith_dp.sv
module addr_arith_dp
  import addr_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       strobes,
  input  logic [W-1:0] hlIn,
  input  logic [W-1:0] pairIn,
  input  logic [W-1:0] spIn,
  input  logic [7:0]   imm,
  input  logic [3:0]   flagsIn,
  output logic [W-1:0] result,
  output logic [1:0]   dest,
  output logic [3:0]   flagsOut
);

  localparam int HALF_TAP = W - 4;  // carry into bit 12 = carry out of bit 11
  localparam int BYTE_HALF = 4;     // carry out of bit 3
  localparam int BYTE_FULL = 8;     // carry out of bit 7

  logic [W-1:0] opA, opB, offsetExt;
  logic [W:0]   sum;
  logic         wideHalf, wideCarry, byteHalf, byteCarry;
  logic [3:0]   flagsNext;
  logic [W-1:0] resultNext;

  assign offsetExt = {{(W-8){imm[7]}}, imm};

  always_comb begin
    case (strobes.aSel)
      A_SP:    opA = spIn;
      A_PAIR:  opA = pairIn;
      default: opA = hlIn;
    endcase
    case (strobes.bSel)
      B_OFFSET: opB = offsetExt;
      B_MINUS1: opB = '1;
      default:  opB = pairIn;
    endcase
  end

  // Single shared adder
  assign sum = {1'b0, opA} + {1'b0, opB};

  // Carry into a bit = a ^ b ^ sum at that bit
  assign wideHalf  = opA[HALF_TAP]  ^ opB[HALF_TAP]  ^ sum[HALF_TAP];
  assign wideCarry = sum[W];
  assign byteHalf  = opA[BYTE_HALF] ^ opB[BYTE_HALF] ^ sum[BYTE_HALF];
  assign byteCarry = opA[BYTE_FULL] ^ opB[BYTE_FULL] ^ sum[BYTE_FULL];

  always_comb begin
    flagsNext = flagsIn;
    case (strobes.flagMode)
      F_WIDE: begin
        flagsNext[FLAG_N] = 1'b0;
        flagsNext[FLAG_H] = wideHalf;
        flagsNext[FLAG_C] = wideCarry;
      end
      F_BYTE: begin
        flagsNext[FLAG_Z] = 1'b0;
        flagsNext[FLAG_N] = 1'b0;
        flagsNext[FLAG_H] = byteHalf;
        flagsNext[FLAG_C] = byteCarry;
      end
      default: ;
    endcase
    resultNext = strobes.zeroResult ? '0 : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      dest     <= DST_NONE;
      flagsOut <= '0;
    end else begin
      result   <= resultNext;
      dest     <= strobes.dest;
      flagsOut <= flagsNext;
    end
  end

endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import addr_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   opSel,
  input  logic [W-1:0] hlIn,
  input  logic [W-1:0] pairIn,
  input  logic [W-1:0] spIn,
  input  logic [7:0]   imm,
  input  logic [3:0]   flagsIn,
  output logic [W-1:0] result,
  output logic [1:0]   dest,
  output logic [3:0]   flagsOut
);

  strobeT strobes;

  addr_arith_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  addr_arith_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .hlIn     (hlIn),
    .pairIn   (pairIn),
    .spIn     (spIn),
    .imm      (imm),
    .flagsIn  (flagsIn),
    .result   (result),
    .dest     (dest),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/addr_arith_checker.sv
module addr_arith_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   opSel,
  input logic [W-1:0] hlIn,
  input logic [W-1:0] pairIn,
  input logic [W-1:0] spIn,
  input logic [7:0]   imm,
  input logic [3:0]   flagsIn,
  input logic [W-1:0] result,
  input logic [1:0]   dest,
  input logic [3:0]   flagsOut
);

  // R3: pair to HL, destination HL, Subtract clear, Zero kept, wrapping sum
  a_r3_pair_to_hl: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd1 |=> dest == 2'd1 && flagsOut[2] == 1'b0 &&
                      flagsOut[3] == $past(flagsIn[3]) &&
                      result == W'($past(hlIn) + $past(pairIn)));

  // R5: offset to SP, Zero and Subtract clear, signed sum
  a_r5_offset_to_sp: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd2 |=> dest == 2'd2 && flagsOut[3:2] == 2'b00 &&
                      result == W'($past(spIn) +
                                   {{(W-8){$past(imm[7])}}, $past(imm)}));

  // R7: SP plus offset to HL
  a_r7_sp_to_hl: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd3 |=> dest == 2'd1 && flagsOut[3:2] == 2'b00 &&
                      result == W'($past(spIn) +
                                   {{(W-8){$past(imm[7])}}, $past(imm)}));

  // R8: decrement keeps flags
  a_r8_dec_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    opSel == 3'd4 |=> dest == 2'd3 && flagsOut == $past(flagsIn) &&
                      result == W'($past(pairIn) - 1'b1));

  // R9: idle codes
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'd0 || opSel > 3'd4) |=> dest == 2'd0 && result == '0 &&
                                        flagsOut == $past(flagsIn));

endmodule

bind addr_arith_unit addr_arith_checker #(.W(W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .opSel    (opSel),
  .hlIn     (hlIn),
  .pairIn   (pairIn),
  .spIn     (spIn),
  .imm      (imm),
  .flagsIn  (flagsIn),
  .result   (result),
  .dest     (dest),
  .flagsOut (flagsOut)
);

// File: tb/addr_arith_unit_tb.sv
`timescale 1ns/1ps
module addr_arith_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = '0;
  logic [15:0] hlIn = '0, pairIn = '0, spIn = '0;
  logic [7:0]  imm = '0;
  logic [3:0]  flagsIn = '0;
  logic [15:0] result;
  logic [1:0]  dest;
  logic [3:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_arith_unit u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .hlIn(hlIn), .pairIn(pairIn),
    .spIn(spIn), .imm(imm), .flagsIn(flagsIn), .result(result),
    .dest(dest), .flagsOut(flagsOut)
  );

  // Reference model from the requirements: returns {result, dest, flags}
  function automatic logic [21:0] model(input logic [2:0] op,
      input logic [15:0] hl, pr, sp, input logic [7:0] im,
      input logic [3:0] fl);
    int off, s, lo;
    logic [15:0] r;
    logic [1:0] d;
    logic [3:0] f;
    off = (int'(im) ^ 'h80) - 'h80;          // R4
    r = 16'h0; d = 2'd0; f = fl;
    case (op)
      3'd1: begin                            // R3
        s = int'(hl) + int'(pr);
        r = s[15:0]; d = 2'd1;
        f = {fl[3], 1'b0,
             ((int'(hl) % 4096) + (int'(pr) % 4096)) >= 4096,
             s >= 65536};
      end
      3'd2, 3'd3: begin                      // R5 R6 R7
        s = int'(sp) + off;
        r = s[15:0];
        d = (op == 3'd2) ? 2'd2 : 2'd1;
        lo = int'(sp[7:0]) + int'(im);
        f = {1'b0, 1'b0,
             ((int'(sp[3:0]) + int'(im[3:0])) >= 16), lo >= 256};
      end
      3'd4: begin                            // R8
        s = int'(pr) + 65535;
        r = s[15:0]; d = 2'd3; f = fl;
      end
      default: ;                             // R9
    endcase
    return {r, d, f};
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R5/R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input string req, input logic [21:0] exp);
    checks++;
    if ({result, dest, flagsOut} !== exp) begin
      errors++;
      $display("FAIL %s: got result=%h dest=%0d flags=%b, expected result=%h dest=%0d flags=%b",
               req, result, dest, flagsOut, exp[21:6], exp[5:4], exp[3:0]);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample at next negedge (R2)
  task automatic runOp(input string req, input logic [2:0] op,
      input logic [15:0] hl, pr, sp, input logic [7:0] im,
      input logic [3:0] fl);
    logic [21:0] exp;
    opSel = op; hlIn = hl; pairIn = pr; spIn = sp; imm = im; flagsIn = fl;
    exp = model(op, hl, pr, sp, im, fl);
    @(posedge clk);
    @(negedge clk);
    checkOut(req, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [21:0] held;
    seed = 32'd12345;
    void'($urandom(seed));
    opSel = 3'd1; hlIn = 16'h1234; pairIn = 16'h1111; flagsIn = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1 in reset", 22'h0);
    rstN = 1'b1;
    opSel = 3'd0; flagsIn = 4'h0;
    @(posedge clk); @(negedge clk);
    checkOut("R1 after reset", 22'h0);

    // R10 wrap and carry taps for R3
    runOp("R10 ffff+1", 3'd1, 16'hFFFF, 16'h0001, 16'h0, 8'h0, 4'h8);
    runOp("R3 bit11 carry only", 3'd1, 16'h0FFF, 16'h0001, 16'h0, 8'h0, 4'h4);
    runOp("R3 bit15 carry only", 3'd1, 16'h8000, 16'h8000, 16'h0, 8'h0, 4'h0);
    runOp("R3 no carry Z kept", 3'd1, 16'h1234, 16'h0100, 16'h0, 8'h0, 4'hF);
    // R4 R6 signed offsets, byte flags
    runOp("R6 bit3 and bit7", 3'd2, 16'h00FF, 16'h0, 16'h00FF, 8'h01, 4'hF);
    runOp("R4 minus one from 0", 3'd2, 16'h0, 16'h0, 16'h0000, 8'hFF, 4'hC);
    runOp("R4 minus one low byte 0f", 3'd2, 16'h0, 16'h0, 16'h000F, 8'hFF, 4'h0);
    runOp("R4 minus 128", 3'd3, 16'h0, 16'h0, 16'h1000, 8'h80, 4'hF);
    runOp("R7 sp to hl", 3'd3, 16'hAAAA, 16'h0, 16'hFFF8, 8'h08, 4'h0);
    // R8 decrement wrap
    runOp("R8 dec zero", 3'd4, 16'h0, 16'h0000, 16'h0, 8'h0, 4'hA);
    runOp("R8 dec", 3'd4, 16'h0, 16'h1000, 16'h0, 8'h0, 4'h5);
    // R9 idle codes
    for (int c = 5; c < 8; c++)
      runOp("R9 idle code", 3'(c), 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 4'h9);
    runOp("R9 idle zero", 3'd0, 16'h1, 16'h1, 16'h1, 8'h1, 4'h6);

    // R2: outputs hold between edges
    runOp("R2 setup", 3'd1, 16'h0102, 16'h0304, 16'h0, 8'h0, 4'h0);
    held = {result, dest, flagsOut};
    opSel = 3'd4; pairIn = 16'h7777;
    #2;
    checkOut("R2 hold before edge", held);
    @(negedge clk);

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (i % 2 == 0) op = 3'($urandom_range(1, 4));
      runOp(reqOf(op), op, 16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule